// File: doc/BRIEF.md
# Spike History and Step Sequencer

This block drives a discrete-time spiking network through its time steps and holds the most recent D spike vectors of the whole network. Every neuron therefore sees the firing state of every other neuron at each delay from 1 to D. It stays idle until the input stage reports that all synaptic weights have reached the neurons. It then loads a stored initial spike history and starts stepping.

In each step the sequencer walks a neuron address from 0 up to N-1, one address per cycle. The neuron array answers each address with that neuron's new firing bit, and the bit is written at that position of the vector for the current step. The finished vector is offered on a valid/ready output so it can be recorded. When the vector is accepted, it enters the delay line as the newest slot, every older slot moves one place deeper, and the oldest slot is dropped. The complete N×D history is driven to all neurons at all times.

A run covers a programmable number of steps and then raises a done flag. A new weights-loaded pulse starts a fresh run from the stored initial history.

Top module: `snn_step_seq`

## Requirements
- R1: After reset, `hist_o` is all zero and `out_valid_o`, `nrn_req_o` and `done_o` are low.
- R2: While idle, changes on `init_hist_i` and `num_steps_i` have no effect: `hist_o` stays zero and no step starts until `wload_done_i` is high at a clock edge.
- R3: The clock edge that samples `wload_done_i` high while idle or done loads `init_hist_i` into `hist_o` and latches `num_steps_i`. Slot d (0 = newest, delay 1) sits at bits [d*N +: N].
- R4: During collection `nrn_req_o` is high and `nrn_addr_o` takes the values 0, 1, …, N-1 on consecutive cycles. The `nrn_bit_i` value present with address a becomes bit a of the emitted vector.
- R5: Once N addresses have been collected, `out_valid_o` is high with the vector on `out_data_o`. While `out_ready_i` is low, the valid signal, the data and `hist_o` all hold.
- R6: On a cycle with valid and ready both high, slot 0 of `hist_o` takes the emitted vector, slot d takes the old slot d-1, and the old oldest slot is discarded.
- R7: Exactly `num_steps_i` vectors are emitted per run. After the last handshake `done_o` is high and neither valid nor request is asserted. A count of zero goes straight to done after the load.
- R8: A `wload_done_i` pulse while done restarts the run from the new initial history with a new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wload_done_i | input | 1 | Weights delivered; starts a run |
| num_steps_i | input | CNT_W | Steps to run, latched at start |
| init_hist_i | input | N*D | Initial spike history, slot d at [d*N +: N] |
| nrn_req_o | output | 1 | Collection in progress |
| nrn_addr_o | output | AW | Address of the neuron whose bit is being stored |
| nrn_bit_i | input | 1 | Firing bit of the addressed neuron |
| hist_o | output | N*D | Delayed spike history broadcast to all neurons |
| out_valid_o | output | 1 | Step vector available |
| out_data_o | output | N | Spike vector of the current step |
| out_ready_i | input | 1 | Recorder accepts the vector |
| done_o | output | 1 | Run complete |

## Verification
The hardest situation to reach is a delay line whose slots all hold different, non-trivial contents, with a stall landing while that history is being consumed. Zero or repeating spike vectors would let a wrong shift or a wrong slot order go unseen. The bench models the neuron array so that each bit depends on both the newest and the oldest slot and also on a step-dependent drive term. It then sweeps several initial histories, step counts from zero to four and stall lengths, running them back to back without reset, so the restart from done is exercised with a history that is not empty.

// File: rtl/snn_seq_pkg.sv
package snn_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_EMIT,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/snn_hist_line.sv
module snn_hist_line #(
  parameter int N = 100,
  parameter int D = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N*D-1:0] init_i,
  input  logic         shift_i,
  input  logic [N-1:0] new_i,
  output logic [N*D-1:0] hist_o
);
  logic [N-1:0] slot_q [D];

  for (genvar d = 0; d < D; d++) begin : g_slot
    logic [N-1:0] src;
    if (d == 0) begin : g_head
      assign src = new_i;
    end else begin : g_tail
      assign src = slot_q[d-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      slot_q[d] <= '0;
      else if (load_i)  slot_q[d] <= init_i[d*N +: N];
      else if (shift_i) slot_q[d] <= src;
    end

    assign hist_o[d*N +: N] = slot_q[d];
  end
endmodule

// File: rtl/snn_spike_collect.sv
module snn_spike_collect #(
  parameter int N  = 100,
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          en_i,
  input  logic          bit_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o,
  output logic [N-1:0]  vec_o
);
  logic [AW-1:0] addr_q;
  logic [N-1:0]  vec_q;

  assign last_o = (addr_q == AW'(N-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      vec_q  <= '0;
    end else if (clear_i) begin
      addr_q <= '0;
    end else if (en_i) begin
      vec_q[addr_q] <= bit_i;
      if (!last_o) addr_q <= addr_q + AW'(1);
    end
  end

  assign addr_o = addr_q;
  assign vec_o  = vec_q;
endmodule

// File: rtl/snn_step_ctrl.sv
module snn_step_ctrl
  import snn_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] num_steps_i,
  input  logic             last_addr_i,
  input  logic             out_ready_i,
  output logic             load_o,
  output logic             collect_o,
  output logic             valid_o,
  output logic             fire_o,
  output logic             done_o
);
  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, lim_q;
  logic             final_step;

  assign load_o     = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign collect_o  = (state_q == ST_COLLECT);
  assign valid_o    = (state_q == ST_EMIT);
  assign fire_o     = valid_o && out_ready_i;
  assign done_o     = (state_q == ST_DONE);
  assign final_step = (cnt_q + CNT_W'(1) == lim_q);

  always_comb begin
    state_d = state_q;
    if (load_o) begin
      state_d = (num_steps_i == '0) ? ST_DONE : ST_COLLECT;
    end else begin
      case (state_q)
        ST_COLLECT: if (last_addr_i) state_d = ST_EMIT;
        ST_EMIT:    if (fire_o) state_d = final_step ? ST_DONE : ST_COLLECT;
        default:    state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lim_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        cnt_q <= '0;
        lim_q <= num_steps_i;
      end else if (fire_o) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/snn_step_seq.sv
module snn_step_seq #(
  parameter int N     = 100,
  parameter int D     = 2,
  parameter int CNT_W = 16,
  localparam int AW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wload_done_i,
  input  logic [CNT_W-1:0] num_steps_i,
  input  logic [N*D-1:0]   init_hist_i,
  output logic             nrn_req_o,
  output logic [AW-1:0]    nrn_addr_o,
  input  logic             nrn_bit_i,
  output logic [N*D-1:0]   hist_o,
  output logic             out_valid_o,
  output logic [N-1:0]     out_data_o,
  input  logic             out_ready_i,
  output logic             done_o
);
  logic load, collect, fire, last_addr;
  logic [N-1:0] cur_vec;

  snn_step_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (wload_done_i),
    .num_steps_i (num_steps_i),
    .last_addr_i (last_addr),
    .out_ready_i (out_ready_i),
    .load_o      (load),
    .collect_o   (collect),
    .valid_o     (out_valid_o),
    .fire_o      (fire),
    .done_o      (done_o)
  );

  snn_spike_collect #(.N(N), .AW(AW)) i_collect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load || fire),
    .en_i    (collect),
    .bit_i   (nrn_bit_i),
    .addr_o  (nrn_addr_o),
    .last_o  (last_addr),
    .vec_o   (cur_vec)
  );

  snn_hist_line #(.N(N), .D(D)) i_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .init_i  (init_hist_i),
    .shift_i (fire),
    .new_i   (cur_vec),
    .hist_o  (hist_o)
  );

  assign nrn_req_o  = collect;
  assign out_data_o = cur_vec;
endmodule

// File: rtl/snn_step_seq_chk.sv
module snn_step_seq_chk #(
  parameter int N     = 100,
  parameter int D     = 2,
  parameter int CNT_W = 16,
  parameter int AW    = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             nrn_req_o,
  input logic [AW-1:0]    nrn_addr_o,
  input logic [N*D-1:0]   hist_o,
  input logic             out_valid_o,
  input logic [N-1:0]     out_data_o,
  input logic             out_ready_i,
  input logic             done_o
);
  a_r4_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nrn_req_o |-> (nrn_addr_o <= AW'(N-1)));

  a_r4_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nrn_req_o && nrn_addr_o != AW'(N-1)) |=>
      (nrn_req_o && nrn_addr_o == $past(nrn_addr_o) + AW'(1)));

  a_r5_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  a_r5_hold_hist: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> $stable(hist_o));

  a_r6_newest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i) |=> (hist_o[N-1:0] == $past(out_data_o)));

  if (D > 1) begin : g_deep
    a_r6_age: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && out_ready_i) |=>
        (hist_o[N*D-1:N] == $past(hist_o[N*(D-1)-1:0])));
  end

  a_r7_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!out_valid_o && !nrn_req_o));

  a_r5_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_valid_o && nrn_req_o));
endmodule

bind snn_step_seq snn_step_seq_chk #(.N(N), .D(D), .CNT_W(CNT_W), .AW(AW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .nrn_req_o   (nrn_req_o),
  .nrn_addr_o  (nrn_addr_o),
  .hist_o      (hist_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_ready_i (out_ready_i),
  .done_o      (done_o)
);

// File: tb/test_snn_step_seq.sv
module test_snn_step_seq;
  localparam int N  = 5;
  localparam int D  = 3;
  localparam int CW = 4;
  localparam int AW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wload = 1'b0;
  logic [CW-1:0] nsteps = '0;
  logic [N*D-1:0] init_h = '0;
  logic req, vld, done, rdy;
  logic [AW-1:0] addr;
  logic nbit;
  logic [N*D-1:0] hist;
  logic [N-1:0] odata;

  int total = 0, bad = 0, k_tb = 0;
  logic [N*D-1:0] model;

  always #2.5 clk = ~clk;

  snn_step_seq #(.N(N), .D(D), .CNT_W(CW)) i_snn_step_seq (
    .clk_i(clk), .rst_ni(rst_n), .wload_done_i(wload), .num_steps_i(nsteps),
    .init_hist_i(init_h), .nrn_req_o(req), .nrn_addr_o(addr), .nrn_bit_i(nbit),
    .hist_o(hist), .out_valid_o(vld), .out_data_o(odata), .out_ready_i(rdy),
    .done_o(done));

  function automatic logic nf(logic [N*D-1:0] h, int i, int k);
    return h[(i+1)%N] ^ h[(D-1)*N+i] ^ (((i*3+k)%4) == 0);
  endfunction

  assign nbit = nf(hist, int'(addr) % N, k_tb);

  task automatic chk(bit ok, string req_s, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req_s, act, exp);
    end
  endtask

  task automatic run(logic [N*D-1:0] ih, int steps, int stall);
    logic [N-1:0] ev;
    @(negedge clk);
    wload = 1'b1; init_h = ih; nsteps = CW'(steps);
    @(negedge clk);
    wload = 1'b0; init_h = ~ih;
    model = ih; k_tb = 0;
    chk(hist == ih, "R3 load", 64'(hist), 64'(ih));
    chk(done == (steps == 0), "R7 zero-count done", 64'(done), 64'(steps == 0));
    for (int s = 0; s < steps; s++) begin
      for (int i = 0; i < N; i++) begin
        chk(req && addr == AW'(i), "R4 address order", 64'({req, addr}), 64'({1'b1, AW'(i)}));
        @(negedge clk);
      end
      for (int i = 0; i < N; i++) ev[i] = nf(model, i, k_tb);
      chk(vld && odata == ev, "R4 vector", 64'({vld, odata}), 64'({1'b1, ev}));
      for (int t = 0; t < stall; t++) begin
        @(negedge clk);
        chk(vld && odata == ev && hist == model, "R5 stall hold",
            64'({vld, odata}), 64'({1'b1, ev}));
      end
      rdy = 1'b1;
      @(negedge clk);
      rdy = 1'b0;
      model = {model[N*(D-1)-1:0], ev};
      k_tb++;
      chk(hist == model, "R6 shift", 64'(hist), 64'(model));
    end
    chk(done && !vld && !req, "R7/R8 done after run", 64'({done, vld, req}), 64'(3'b100));
  endtask

  initial begin
    rdy = 1'b0;
    #12;
    chk(hist == '0 && !vld && !req && !done, "R1 reset", 64'({hist, vld, req, done}), 64'(0));
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      init_h = N*D'(c * 4933 + 7); nsteps = CW'(c + 1);
      @(negedge clk);
      chk(hist == '0 && !vld && !req && !done, "R2 idle ignores", 64'(hist), 64'(0));
    end
    for (int p = 0; p < 8; p++)
      run(N*D'((p * 11117 + p * p * 389 + 21) ^ (p << 9)), p % 5, p % 3);
    run({N*D{1'b1}}, 4, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule